// File: doc/BRIEF.md
# Induction Motor Emulator Core

This block is a real-time, fixed-point model of an induction machine. It holds four electromagnetic states: the stator currents and rotor fluxes on two orthogonal axes. On each sample pulse from an external sequencer it advances them by one forward-Euler step, x[k+1] = A_d·x[k] + B_d·u[k]. The sample period is already folded into the coefficients. The inputs are the two-axis stator voltages and the electrical speed, all in per-unit. After the state update the block forms the electromagnetic torque from the new states. When the torque is ready it raises a one-cycle done flag.

All arithmetic runs through one shared 18x18 multiplier and a wide accumulator under a local 19-step schedule. Signals use signed Q2.16 and coefficients use signed Q2.14. Each write-back floors to the destination format and then clips to it, and any clip sets a sticky flag. The two speed-dependent matrix entries are built at the start of every update as a coefficient times the latched speed. A host can retune the eight coefficients at any time through a write port. Writes land in a staging bank, and each update copies that bank into a working bank, so one update always sees one consistent coefficient set.

Top module: `im_emulator`

## Requirements
- R1: After reset, all state, torque, busy_o, done_o and sat_o outputs are 0, and both coefficient banks hold 0.
- R2: A start_i pulse while idle raises busy_o. done_o is high for exactly one cycle, beginning 19 rising edges after the edge that accepted the start, and the outputs are final at that point.
- R3: With speed terms gi and gf, the update is: i_a' = c0·i_a + c1·ψ_a + gi·ψ_b + c3·v_a; i_b' = c0·i_b + c1·ψ_b − gi·ψ_a + c3·v_b; ψ_a' = c4·i_a + c5·ψ_a − gf·ψ_b; ψ_b' = c4·i_b + c5·ψ_b + gf·ψ_a. Sums are exact. Each result is shifted right arithmetically by 14 bits (floor) into Q2.16.
- R4: The speed terms are gi = c2·w and gf = c6·w. Each is shifted right arithmetically by 16 bits into Q2.14 and clipped to 16 bits.
- R5: From the updated states, cross = (ψ_a·i_b − ψ_b·i_a) >>> 16, clipped to Q2.16. Torque = (c7·cross) >>> 14, clipped to Q2.16.
- R6: Every write-back that falls outside its destination range is clipped to the largest or smallest code, for example 131071 or −131072 for Q2.16. sat_o then goes to 1 and stays there until reset.
- R7: A start_i pulse while busy_o is high is ignored. The update runs to completion exactly once.
- R8: A coefficient write (coef_addr_i 0..7 selects c0..c7, data in Q2.14) made while busy_o is high does not affect the running update. It takes effect from the next update.
- R9: A coefficient write in the same cycle as an accepted start is used by the update that starts.
- R10: Voltages and speed are latched at the accepted start. Changes to them while busy_o is high do not affect that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Sample strobe, starts one update |
| v_alpha_i | input | 18 | Stator voltage, axis a, Q2.16 |
| v_beta_i | input | 18 | Stator voltage, axis b, Q2.16 |
| speed_i | input | 18 | Electrical speed, Q2.16 |
| coef_we_i | input | 1 | Coefficient write enable |
| coef_addr_i | input | 3 | Coefficient index c0..c7 |
| coef_data_i | input | 16 | Coefficient value, Q2.14 |
| i_alpha_o | output | 18 | Stator current a, Q2.16 |
| i_beta_o | output | 18 | Stator current b, Q2.16 |
| flux_alpha_o | output | 18 | Rotor flux a, Q2.16 |
| flux_beta_o | output | 18 | Rotor flux b, Q2.16 |
| torque_o | output | 18 | Electromagnetic torque, Q2.16 |
| busy_o | output | 1 | Update in progress |
| done_o | output | 1 | One-cycle update-complete pulse |
| sat_o | output | 1 | Sticky clip flag |

## Verification
A coefficient write can land in the same cycle as an accepted start, and it can also land while an update is running. The bench provokes both cases on the gain c3. In the first case it expects the new value inside the update that just began. In the second case it expects the old value for the running update and the new value from the following one. In every case the outputs are compared against a bench-side integer model of the equations, and a wrong bank hand-off shows up as a current mismatch. Starts issued during busy and input changes during busy are judged in the same way, by exactly one update and by unchanged results.

// File: rtl/im_emu_pkg.sv
package im_emu_pkg;
  localparam int SIG_W   = 18;
  localparam int COEF_W  = 16;
  localparam int ACC_W   = 40;
  localparam int N_COEF  = 8;
  localparam int N_STEP  = 19;
  localparam int STEP_W  = $clog2(N_STEP);
  localparam int CA_W    = $clog2(N_COEF);

  typedef enum logic [3:0] {
    D_NONE, D_GI, D_GF, D_N0, D_N1, D_N2, D_N3, D_CROSS, D_TE
  } dst_e;

  // a_sel: 0..7 coef, 8 gi, 9 gf, 10 psi_a, 11 psi_b
  // b_sel: 0 i_a, 1 i_b, 2 psi_a, 3 psi_b, 4 v_a, 5 v_b, 6 w, 7 cross
  typedef struct packed {
    logic [3:0] a_sel;
    logic [2:0] b_sel;
    logic       clr;
    logic       neg;
    dst_e       dst;
    logic       sh_hi;  // shift by 16 instead of 14
  } op_t;

  function automatic op_t mk(logic [3:0] a, logic [2:0] b, logic c, logic n,
                             dst_e d, logic h);
    op_t o;
    o.a_sel = a; o.b_sel = b; o.clr = c; o.neg = n; o.dst = d; o.sh_hi = h;
    return o;
  endfunction

  function automatic op_t op_decode(logic [STEP_W-1:0] s);
    op_t o;
    case (s)
      5'd0:  o = mk(4'd2,  3'd6, 1'b1, 1'b0, D_GI,    1'b1);
      5'd1:  o = mk(4'd6,  3'd6, 1'b1, 1'b0, D_GF,    1'b1);
      5'd2:  o = mk(4'd0,  3'd0, 1'b1, 1'b0, D_NONE,  1'b0);
      5'd3:  o = mk(4'd1,  3'd2, 1'b0, 1'b0, D_NONE,  1'b0);
      5'd4:  o = mk(4'd8,  3'd3, 1'b0, 1'b0, D_NONE,  1'b0);
      5'd5:  o = mk(4'd3,  3'd4, 1'b0, 1'b0, D_N0,    1'b0);
      5'd6:  o = mk(4'd0,  3'd1, 1'b1, 1'b0, D_NONE,  1'b0);
      5'd7:  o = mk(4'd1,  3'd3, 1'b0, 1'b0, D_NONE,  1'b0);
      5'd8:  o = mk(4'd8,  3'd2, 1'b0, 1'b1, D_NONE,  1'b0);
      5'd9:  o = mk(4'd3,  3'd5, 1'b0, 1'b0, D_N1,    1'b0);
      5'd10: o = mk(4'd4,  3'd0, 1'b1, 1'b0, D_NONE,  1'b0);
      5'd11: o = mk(4'd5,  3'd2, 1'b0, 1'b0, D_NONE,  1'b0);
      5'd12: o = mk(4'd9,  3'd3, 1'b0, 1'b1, D_N2,    1'b0);
      5'd13: o = mk(4'd4,  3'd1, 1'b1, 1'b0, D_NONE,  1'b0);
      5'd14: o = mk(4'd5,  3'd3, 1'b0, 1'b0, D_NONE,  1'b0);
      5'd15: o = mk(4'd9,  3'd2, 1'b0, 1'b0, D_N3,    1'b0);
      5'd16: o = mk(4'd10, 3'd1, 1'b1, 1'b0, D_NONE,  1'b1);
      5'd17: o = mk(4'd11, 3'd0, 1'b0, 1'b1, D_CROSS, 1'b1);
      5'd18: o = mk(4'd7,  3'd7, 1'b1, 1'b0, D_TE,    1'b0);
      default: o = mk(4'd0, 3'd0, 1'b1, 1'b0, D_NONE, 1'b0);
    endcase
    return o;
  endfunction
endpackage

// File: rtl/im_emu_seq.sv
module im_emu_seq
  import im_emu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [STEP_W-1:0] step_o
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(N_STEP - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
      step_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (!busy_o) begin
        if (start_i) begin
          busy_o <= 1'b1;
          step_o <= '0;
        end
      end else if (step_o == LAST) begin
        busy_o <= 1'b0;
        done_o <= 1'b1;
      end else begin
        step_o <= step_o + 1'b1;
      end
    end
  end

  p_done_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_after_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(busy_o));
  p_ignore_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && step_o != LAST) |=> (busy_o && step_o == $past(step_o) + 1'b1));
endmodule

// File: rtl/im_emu_coef.sv
module im_emu_coef
  import im_emu_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [CA_W-1:0]          addr_i,
  input  logic [COEF_W-1:0]        data_i,
  input  logic                     load_i,
  output logic [N_COEF*COEF_W-1:0] coef_o
);
  for (genvar g = 0; g < N_COEF; g++) begin : g_coef
    logic [COEF_W-1:0] stage_q;
    logic              hit;
    assign hit = we_i && (addr_i == CA_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q                    <= '0;
        coef_o[g*COEF_W +: COEF_W] <= '0;
      end else begin
        if (hit) stage_q <= data_i;
        // forward a same-cycle write into the working bank
        if (load_i) coef_o[g*COEF_W +: COEF_W] <= hit ? data_i : stage_q;
      end
    end
  end
endmodule

// File: rtl/im_emu_mac.sv
module im_emu_mac
  import im_emu_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    clr_i,
  input  logic                    neg_i,
  input  logic signed [SIG_W-1:0] a_i,
  input  logic signed [SIG_W-1:0] b_i,
  output logic signed [ACC_W-1:0] sum_o
);
  logic signed [2*SIG_W-1:0] prod;
  logic signed [ACC_W-1:0]   prod_x, acc_q;

  assign prod   = a_i * b_i;
  assign prod_x = ACC_W'(prod);
  assign sum_o  = (clr_i ? '0 : acc_q) + (neg_i ? -prod_x : prod_x);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_q <= '0;
    else if (en_i) acc_q <= sum_o;
  end
endmodule

// File: rtl/im_emulator.sv
module im_emulator
  import im_emu_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic signed [17:0]      v_alpha_i,
  input  logic signed [17:0]      v_beta_i,
  input  logic signed [17:0]      speed_i,
  input  logic                    coef_we_i,
  input  logic [2:0]              coef_addr_i,
  input  logic [15:0]             coef_data_i,
  output logic signed [17:0]      i_alpha_o,
  output logic signed [17:0]      i_beta_o,
  output logic signed [17:0]      flux_alpha_o,
  output logic signed [17:0]      flux_beta_o,
  output logic signed [17:0]      torque_o,
  output logic                    busy_o,
  output logic                    done_o,
  output logic                    sat_o
);
  localparam logic signed [ACC_W-1:0] SIG_MAX  = ACC_W'((1 << (SIG_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] SIG_MIN  = -SIG_MAX - 1;
  localparam logic signed [ACC_W-1:0] COEF_MAX = ACC_W'((1 << (COEF_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] COEF_MIN = -COEF_MAX - 1;

  logic [STEP_W-1:0]          step;
  logic                       start_ok;
  logic [N_COEF*COEF_W-1:0]   coef_act;
  op_t                        op;
  logic signed [SIG_W-1:0]    st_q [4];  // i_a, i_b, psi_a, psi_b
  logic signed [SIG_W-1:0]    nx_q [3];
  logic signed [COEF_W-1:0]   gi_q, gf_q;
  logic signed [SIG_W-1:0]    cross_q, te_q, va_q, vb_q, w_q;
  logic signed [SIG_W-1:0]    a_op, b_op;
  logic signed [ACC_W-1:0]    sum, shv, wb_v, lim_hi, lim_lo;
  logic                       clip, sat_q;

  assign start_ok = start_i && !busy_o;
  assign op       = op_decode(step);

  im_emu_seq u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .busy_o(busy_o), .done_o(done_o), .step_o(step)
  );

  im_emu_coef u_coef (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(coef_we_i), .addr_i(coef_addr_i),
    .data_i(coef_data_i), .load_i(start_ok), .coef_o(coef_act)
  );

  always_comb begin
    case (op.a_sel)
      4'd8:    a_op = SIG_W'(gi_q);
      4'd9:    a_op = SIG_W'(gf_q);
      4'd10:   a_op = st_q[2];
      4'd11:   a_op = st_q[3];
      default: a_op = SIG_W'($signed(coef_act[op.a_sel[2:0]*COEF_W +: COEF_W]));
    endcase
    case (op.b_sel)
      3'd4:    b_op = va_q;
      3'd5:    b_op = vb_q;
      3'd6:    b_op = w_q;
      3'd7:    b_op = cross_q;
      default: b_op = st_q[op.b_sel[1:0]];
    endcase
  end

  im_emu_mac u_mac (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(busy_o), .clr_i(op.clr),
    .neg_i(op.neg), .a_i(a_op), .b_i(b_op), .sum_o(sum)
  );

  // floor to destination format, then clip
  always_comb begin
    shv = op.sh_hi ? (sum >>> 16) : (sum >>> 14);
    if (op.dst == D_GI || op.dst == D_GF) begin
      lim_hi = COEF_MAX; lim_lo = COEF_MIN;
    end else begin
      lim_hi = SIG_MAX;  lim_lo = SIG_MIN;
    end
    clip = (shv > lim_hi) || (shv < lim_lo);
    wb_v = (shv > lim_hi) ? lim_hi : ((shv < lim_lo) ? lim_lo : shv);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 4; i++) st_q[i] <= '0;
      for (int i = 0; i < 3; i++) nx_q[i] <= '0;
      gi_q <= '0; gf_q <= '0; cross_q <= '0; te_q <= '0;
      va_q <= '0; vb_q <= '0; w_q <= '0; sat_q <= 1'b0;
    end else begin
      if (start_ok) begin
        va_q <= v_alpha_i; vb_q <= v_beta_i; w_q <= speed_i;
      end
      if (busy_o) begin
        if (op.dst != D_NONE && clip) sat_q <= 1'b1;
        case (op.dst)
          D_GI:    gi_q    <= wb_v[COEF_W-1:0];
          D_GF:    gf_q    <= wb_v[COEF_W-1:0];
          D_N0:    nx_q[0] <= wb_v[SIG_W-1:0];
          D_N1:    nx_q[1] <= wb_v[SIG_W-1:0];
          D_N2:    nx_q[2] <= wb_v[SIG_W-1:0];
          D_N3: begin
            st_q[0] <= nx_q[0]; st_q[1] <= nx_q[1];
            st_q[2] <= nx_q[2]; st_q[3] <= wb_v[SIG_W-1:0];
          end
          D_CROSS: cross_q <= wb_v[SIG_W-1:0];
          D_TE:    te_q    <= wb_v[SIG_W-1:0];
          default: ;
        endcase
      end
    end
  end

  assign i_alpha_o    = st_q[0];
  assign i_beta_o     = st_q[1];
  assign flux_alpha_o = st_q[2];
  assign flux_beta_o  = st_q[3];
  assign torque_o     = te_q;
  assign sat_o        = sat_q;

  p_state_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> $stable({st_q[0], st_q[1], st_q[2], st_q[3], te_q}));
  p_coef_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(coef_act));
  p_inputs_latched_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable({va_q, vb_q, w_q}));
  p_sat_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sat_q |=> sat_q);
endmodule

// File: tb/im_emulator_tb.sv
module im_emulator_tb_top;
  logic clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0, coef_we_i = 1'b0;
  logic signed [17:0] v_alpha_i = '0, v_beta_i = '0, speed_i = '0;
  logic [2:0]  coef_addr_i = '0;
  logic [15:0] coef_data_i = '0;
  logic signed [17:0] i_alpha_o, i_beta_o, flux_alpha_o, flux_beta_o, torque_o;
  logic busy_o, done_o, sat_o;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #10 clk_i = ~clk_i;

  im_emulator dut_i (.*);

  // bench model
  longint m_st[4], m_te;
  longint m_sh[8], m_act[8];
  bit     m_sat;

  localparam int NV = 6;
  localparam int VEC [NV][3] = '{
    '{32768, 0, 6554}, '{-20000, 30000, 13107}, '{65535, -65536, -32768},
    '{0, 0, 0}, '{-65536, 65535, 65535}, '{12345, -54321, -1}};

  function automatic longint sat(longint v, int w);
    longint mx = (64'sd1 <<< (w - 1)) - 1;
    if (v > mx) begin m_sat = 1; return mx; end
    if (v < -mx - 1) begin m_sat = 1; return -mx - 1; end
    return v;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 4; i++) m_st[i] = 0;
    for (int i = 0; i < 8; i++) begin m_sh[i] = 0; m_act[i] = 0; end
    m_te = 0; m_sat = 0;
  endtask

  task automatic model_step(longint va, longint vb, longint w);
    longint c[8], gi, gf, n[4], cr;
    for (int i = 0; i < 8; i++) c[i] = m_act[i];
    gi = sat((c[2] * w) >>> 16, 16);
    gf = sat((c[6] * w) >>> 16, 16);
    n[0] = sat((c[0]*m_st[0] + c[1]*m_st[2] + gi*m_st[3] + c[3]*va) >>> 14, 18);
    n[1] = sat((c[0]*m_st[1] + c[1]*m_st[3] - gi*m_st[2] + c[3]*vb) >>> 14, 18);
    n[2] = sat((c[4]*m_st[0] + c[5]*m_st[2] - gf*m_st[3]) >>> 14, 18);
    n[3] = sat((c[4]*m_st[1] + c[5]*m_st[3] + gf*m_st[2]) >>> 14, 18);
    for (int i = 0; i < 4; i++) m_st[i] = n[i];
    cr   = sat((m_st[2]*m_st[1] - m_st[3]*m_st[0]) >>> 16, 18);
    m_te = sat((c[7] * cr) >>> 14, 18);
  endtask

  task automatic chk(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_outputs(string req);
    chk({req, " i_alpha"}, i_alpha_o, m_st[0]);
    chk({req, " i_beta"}, i_beta_o, m_st[1]);
    chk({req, " flux_alpha"}, flux_alpha_o, m_st[2]);
    chk({req, " flux_beta"}, flux_beta_o, m_st[3]);
    chk({req, " torque (R5)"}, torque_o, m_te);
    chk("R6 sat_o", longint'(sat_o), longint'(m_sat));
  endtask

  task automatic write_coef(int a, int d);
    @(negedge clk_i);
    coef_we_i = 1; coef_addr_i = 3'(a); coef_data_i = 16'(d);
    m_sh[a] = longint'($signed(16'(d)));
    @(negedge clk_i);
    coef_we_i = 0;
  endtask

  // mode: 0 plain, 1 start during busy (R7), 2 write during busy (R8),
  //       3 write with start (R9), 4 inputs change during busy (R10)
  task automatic run(int va, int vb, int w, int mode, int wa, int wd, string req);
    int cnt = 0;
    @(negedge clk_i);
    v_alpha_i = 18'(va); v_beta_i = 18'(vb); speed_i = 18'(w); start_i = 1;
    if (mode == 3) begin
      coef_we_i = 1; coef_addr_i = 3'(wa); coef_data_i = 16'(wd);
      m_sh[wa] = longint'($signed(16'(wd)));
    end
    for (int i = 0; i < 8; i++) m_act[i] = m_sh[i];
    @(negedge clk_i);
    start_i = 0; coef_we_i = 0;
    while (!done_o && cnt < 40) begin
      if (cnt == 4) begin
        if (mode == 1) start_i = 1;
        if (mode == 2) begin
          coef_we_i = 1; coef_addr_i = 3'(wa); coef_data_i = 16'(wd);
          m_sh[wa] = longint'($signed(16'(wd)));
        end
        if (mode == 4) begin
          v_alpha_i = 18'(-va / 2 + 7); v_beta_i = 18'(vb / 3 - 5); speed_i = 18'(-w);
        end
      end
      if (cnt == 5) begin start_i = 0; coef_we_i = 0; end
      @(negedge clk_i);
      cnt++;
    end
    chk("R2 done latency", cnt, 19);
    model_step(va, vb, w);
    chk_outputs(req);
    @(negedge clk_i);
    chk("R2 done one-cycle", longint'(done_o), 0);
    chk("R7 busy idle after done", longint'(busy_o), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 reset i_alpha", i_alpha_o, 0);
    chk("R1 reset flux_beta", flux_beta_o, 0);
    chk("R1 reset torque", torque_o, 0);
    chk("R1 reset busy", longint'(busy_o), 0);
    chk("R1 reset done", longint'(done_o), 0);
    chk("R1 reset sat", longint'(sat_o), 0);

    write_coef(0, 15565); write_coef(1, 328);   write_coef(2, 819);
    write_coef(3, 1638);  write_coef(4, 16);    write_coef(5, 16351);
    write_coef(6, 164);   write_coef(7, 16384);

    // R3 R4 R5 vector walk
    for (int k = 0; k < NV; k++)
      run(VEC[k][0], VEC[k][1], VEC[k][2], 0, 0, 0, "R3");
    for (int k = 0; k < NV; k++)
      run(VEC[k][0], VEC[k][1], VEC[k][2], 0, 0, 0, "R4");

    run(40000, -30000, 20000, 1, 0, 0, "R7");
    run(-30000, 25000, -15000, 4, 0, 0, "R10");
    run(50000, 50000, 9000, 2, 3, 8000, "R8 old coef");
    run(50000, 50000, 9000, 0, 0, 0, "R8 new coef");
    run(-45000, 12000, 30000, 3, 3, 3000, "R9");

    // R6 clipping
    write_coef(0, 32767);
    write_coef(3, 32767);
    run(65535, -65536, 0, 0, 0, 0, "R6 step1");
    run(65535, -65536, 0, 0, 0, 0, "R6 step2");
    chk("R6 clip high", i_alpha_o, 131071);
    chk("R6 clip low", i_beta_o, -131072);
    write_coef(0, 15565);
    write_coef(3, 1638);
    run(1000, -1000, 500, 0, 0, 0, "R6 sticky");
    chk("R6 sticky flag", longint'(sat_o), 1);

    // R1 reset again
    @(negedge clk_i);
    rst_ni = 0;
    @(negedge clk_i);
    rst_ni = 1;
    model_reset();
    @(negedge clk_i);
    chk("R1 re-reset i_beta", i_beta_o, 0);
    chk("R1 re-reset sat", longint'(sat_o), 0);
    run(30000, 30000, 30000, 0, 0, 0, "R1 zero coefs");

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule